// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up noisy digital inputs before the rest of the chip sees them. It holds four shared filter settings. Each setting pairs a sample rate, which is the system clock divided by a power of two from 1 up to 2^31, with a pipeline depth of 2, 3, 5 or 8 samples. Every pin picks one of the four settings through its own 3-bit select field, or it bypasses filtering altogether. A filtered pin shifts its raw level into a short pipeline each time its setting's sample strobe fires. Its output only moves to a new level once every sample inside the chosen depth agrees on that level.

The four settings are written through one 32-bit configuration word with a one-cycle write strobe. This is a plain control write: it has no handshake and no back-pressure, and it takes effect at the clock edge where the strobe is sampled. A single free-running counter serves all settings and produces one sample-enable strobe per setting. Pins therefore carry no prescaler of their own, only the pipeline and one output flop. The raw inputs are expected to be already synchronous to the clock.

Top module: `glitch_filter_top`

## Requirements
- R1: During and right after reset, every filtered output is 0 and every pin pipeline holds all zeros.
- R2: A configuration write with bits [31:30] equal to 01 updates the setting named by bits [29:28]. Its depth code is taken from bits [6:5] and its rate exponent from bits [4:0]. Bits [27:7] have no effect.
- R3: A configuration write whose bits [31:30] differ from 01 changes no setting.
- R4: Depth codes 0, 1, 2 and 3 give pipeline depths of 2, 3, 5 and 8 samples.
- R5: The shared counter starts at 0 at reset and increments every cycle. The strobe of a setting with rate exponent r is high exactly in the cycles where the counter's low r bits are all ones, so it fires once every 2^r cycles and every cycle when r is 0.
- R6: A filtered output goes to 1 only when the most recent depth samples are all 1. It goes to 0 only when they are all 0. Otherwise it holds, and it never changes in a cycle without a strobe from the selected setting.
- R7: A pin select of 1ss filters the pin with setting ss. A select of 0xx bypasses the filter, so the output equals the raw input in the same cycle.
- R8: After reset, settings 0 to 3 are: depth 2 at divide-by-1, depth 3 at divide-by-32, depth 5 at divide-by-2^19, and depth 8 at divide-by-2^22.
- R9: A sample is taken at the clock edge that ends a strobe cycle. The output reflects that sample right after the same edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle write strobe for cfg_word |
| cfg_word | input | 32 | Setting write word: tag [31:30], index [29:28], depth code [6:5], rate exponent [4:0] |
| pin_raw | input | N_PINS | Raw synchronous pin levels |
| pin_sel | input | 3*N_PINS | Per-pin select, 3 bits per pin, pin p at [3p+2:3p] |
| pin_out | output | N_PINS | Filtered or bypassed pin levels |
| samp_en | output | 4 | Per-setting sample strobes |

## Verification
The bench aims at runs of samples that are one short of the depth. A design that counted the depth wrong would let a 7-sample pulse through at depth 8, or would hold back a valid 8-sample level. It checks the strobe phase from the first cycle after reset. A counter with an off-by-one phase would move the setting-1 strobe away from cycle 31 and shift every sampled edge. Writes with a bad tag, and writes with junk in the unused middle bits, are checked through the strobes and outputs: decoding the wrong field would change the rate or depth, and the model would catch it. Random selects switch pins between settings and bypass while they are in mid-pipeline, which exposes any design that resets or mis-shifts a pipeline when its setting changes.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int GF_NUM_SET   = 4;
  localparam int GF_IDX_W     = $clog2(GF_NUM_SET);
  localparam int GF_RATE_W    = 5;
  localparam int GF_DCODE_W   = 2;
  localparam int GF_MAX_DEPTH = 8;
  localparam int GF_SEL_W     = 1 + GF_IDX_W;
  localparam int GF_CNT_W     = 2 ** GF_RATE_W;
  localparam int GF_WORD_W    = 32;

  // configuration word field positions
  localparam int GF_TAG_LSB   = 30;
  localparam int GF_IDX_LSB   = 28;
  localparam int GF_DCODE_LSB = 5;
  localparam int GF_RATE_LSB  = 0;
  localparam logic [1:0] GF_CFG_TAG = 2'b01;

  typedef struct packed {
    logic [GF_DCODE_W-1:0] dcode;
    logic [GF_RATE_W-1:0]  rate;
  } gf_setting_t;

  function automatic logic [GF_MAX_DEPTH-1:0] gf_window(input logic [GF_DCODE_W-1:0] dcode);
    case (dcode)
      2'd0:    return 8'h03;
      2'd1:    return 8'h07;
      2'd2:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic gf_setting_t gf_reset_setting(input int idx);
    gf_setting_t s;
    case (idx)
      0:       s = '{dcode: 2'd0, rate: 5'd0};
      1:       s = '{dcode: 2'd1, rate: 5'd5};
      2:       s = '{dcode: 2'd2, rate: 5'd19};
      default: s = '{dcode: 2'd3, rate: 5'd22};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gf_cfg_bank.sv
module gf_cfg_bank
  import gf_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [GF_WORD_W-1:0]                  cfg_word,
  output gf_setting_t [GF_NUM_SET-1:0]          set_q
);
  logic                tag_ok;
  logic [GF_IDX_W-1:0] wr_idx;
  gf_setting_t         wr_val;
  logic                cfg_unused;

  assign tag_ok     = (cfg_word[GF_TAG_LSB +: 2] == GF_CFG_TAG);
  assign wr_idx     = cfg_word[GF_IDX_LSB +: GF_IDX_W];
  assign wr_val     = gf_setting_t'({cfg_word[GF_DCODE_LSB +: GF_DCODE_W],
                                     cfg_word[GF_RATE_LSB +: GF_RATE_W]});
  assign cfg_unused = ^cfg_word[GF_IDX_LSB-1:GF_DCODE_LSB+GF_DCODE_W];

  genvar k;
  generate
    for (k = 0; k < GF_NUM_SET; k++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          set_q[k] <= gf_reset_setting(k);
        else if (cfg_we && tag_ok && (wr_idx == GF_IDX_W'(k)))
          set_q[k] <= wr_val;
      end

      // R2: a tagged write lands in the addressed setting
      p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && tag_ok && wr_idx == GF_IDX_W'(k)) |=>
          (set_q[k] == gf_setting_t'({$past(cfg_word[GF_DCODE_LSB +: GF_DCODE_W]),
                                      $past(cfg_word[GF_RATE_LSB +: GF_RATE_W])})));
    end
  endgenerate

  // R3: writes without the tag leave every setting alone
  p_bad_tag_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !tag_ok) |=> $stable(set_q));
endmodule

// File: rtl/gf_strobe_gen.sv
module gf_strobe_gen
  import gf_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [GF_NUM_SET-1:0][GF_RATE_W-1:0]  rate,
  output logic [GF_NUM_SET-1:0]                 samp_en
);
  logic [GF_CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + GF_CNT_W'(1);
  end

  genvar k;
  generate
    for (k = 0; k < GF_NUM_SET; k++) begin : g_strb
      logic [GF_CNT_W-1:0] low_mask;
      assign low_mask   = (GF_CNT_W'(1) << rate[k]) - GF_CNT_W'(1);
      assign samp_en[k] = &(cnt_q | ~low_mask);

      // R5: divide-by-1 samples every cycle
      p_rate0_every_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate[k] == '0) |-> samp_en[k]);

      // R5: a divided strobe never lasts two cycles
      p_strobe_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en[k] && rate[k] != '0) |=> (rate[k] == '0 || !samp_en[k]));
    end
  endgenerate
endmodule

// File: rtl/gf_pin_filter.sv
module gf_pin_filter
  import gf_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  pin_raw,
  input  logic [GF_SEL_W-1:0]                   pin_sel,
  input  logic [GF_NUM_SET-1:0]                 samp_en,
  input  logic [GF_NUM_SET-1:0][GF_DCODE_W-1:0] dcode,
  output logic                                  pin_out
);
  logic                     use_filt;
  logic [GF_IDX_W-1:0]      set_idx;
  logic                     take;
  logic [GF_MAX_DEPTH-1:0]  win;
  logic [GF_MAX_DEPTH-1:0]  pipe_q;
  logic [GF_MAX_DEPTH-1:0]  pipe_nxt;
  logic                     all_hi;
  logic                     all_lo;
  logic                     filt_q;

  assign use_filt = pin_sel[GF_SEL_W-1];
  assign set_idx  = pin_sel[GF_IDX_W-1:0];
  assign take     = use_filt && samp_en[set_idx];
  assign win      = gf_window(dcode[set_idx]);
  assign pipe_nxt = {pipe_q[GF_MAX_DEPTH-2:0], pin_raw};
  assign all_hi   = &(pipe_nxt | ~win);
  assign all_lo   = ~|(pipe_nxt & win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      filt_q <= 1'b0;
    end else if (take) begin
      pipe_q <= pipe_nxt;
      if (all_hi)      filt_q <= 1'b1;
      else if (all_lo) filt_q <= 1'b0;
    end
  end

  assign pin_out = use_filt ? filt_q : pin_raw;

  // R6: no strobe, no change
  p_hold_without_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(filt_q));

  // R6: a rise follows at least two high samples
  p_rise_after_highs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> (pipe_q[1:0] == 2'b11));

  // R6: a fall follows at least two low samples
  p_fall_after_lows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> (pipe_q[1:0] == 2'b00));
endmodule

// File: rtl/glitch_filter_top.sv
module glitch_filter_top
  import gf_pkg::*;
#(
  parameter int N_PINS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [GF_WORD_W-1:0]         cfg_word,
  input  logic [N_PINS-1:0]            pin_raw,
  input  logic [N_PINS*GF_SEL_W-1:0]   pin_sel,
  output logic [N_PINS-1:0]            pin_out,
  output logic [GF_NUM_SET-1:0]        samp_en
);
  gf_setting_t [GF_NUM_SET-1:0]          set_q;
  logic [GF_NUM_SET-1:0][GF_RATE_W-1:0]  rate_v;
  logic [GF_NUM_SET-1:0][GF_DCODE_W-1:0] dcode_v;

  gf_cfg_bank i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_word (cfg_word),
    .set_q    (set_q)
  );

  genvar k;
  generate
    for (k = 0; k < GF_NUM_SET; k++) begin : g_split
      assign rate_v[k]  = set_q[k].rate;
      assign dcode_v[k] = set_q[k].dcode;
    end
  endgenerate

  gf_strobe_gen i_strb (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate    (rate_v),
    .samp_en (samp_en)
  );

  genvar p;
  generate
    for (p = 0; p < N_PINS; p++) begin : g_pin
      gf_pin_filter i_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_raw[p]),
        .pin_sel (pin_sel[p*GF_SEL_W +: GF_SEL_W]),
        .samp_en (samp_en),
        .dcode   (dcode_v),
        .pin_out (pin_out[p])
      );
    end
  endgenerate
endmodule

// File: tb/test_glitch_filter_top.sv
module test_glitch_filter_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [31:0]     cfg_word = '0;
  logic [NP-1:0]   pin_raw = '0;
  logic [NP*3-1:0] pin_sel = '0;
  logic [NP-1:0]   pin_out;
  logic [3:0]      samp_en;

  glitch_filter_top #(.N_PINS(NP)) i_glitch_filter_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .pin_raw(pin_raw), .pin_sel(pin_sel), .pin_out(pin_out), .samp_en(samp_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [1:0]  m_dc [4];
  logic [4:0]  m_rate [4];
  logic [7:0]  m_pipe [NP];
  logic        m_out [NP];
  logic [31:0] m_k;
  int          hold_left [NP];

  function automatic bit exp_strobe(input logic [31:0] k, input logic [4:0] r);
    logic [31:0] mask;
    mask = (32'd1 << r) - 32'd1;
    return (k & mask) == mask;
  endfunction

  function automatic int depth_of(input logic [1:0] dc);
    case (dc)
      2'd0: return 2;
      2'd1: return 3;
      2'd2: return 5;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at k=%0d: actual=%0d expected=%0d", tag, m_k, act, exp);
    end
  endtask

  task automatic tick();
    #1;
    for (int s = 0; s < 4; s++)
      check(samp_en[s] == exp_strobe(m_k, m_rate[s]), "R5", samp_en[s], exp_strobe(m_k, m_rate[s]));
    for (int p = 0; p < NP; p++) begin
      if (pin_sel[p*3+2]) check(pin_out[p] == m_out[p], "R6", pin_out[p], m_out[p]);
      else                check(pin_out[p] == pin_raw[p], "R7", pin_out[p], pin_raw[p]);
    end
    for (int p = 0; p < NP; p++) begin
      int idx;
      idx = int'(pin_sel[p*3 +: 2]);
      if (pin_sel[p*3+2] && exp_strobe(m_k, m_rate[idx])) begin
        logic [7:0] nxt;
        bit hi, lo;
        nxt = {m_pipe[p][6:0], pin_raw[p]};
        hi = 1; lo = 1;
        for (int i = 0; i < depth_of(m_dc[idx]); i++) begin
          if (!nxt[i]) hi = 0;
          if (nxt[i])  lo = 0;
        end
        m_pipe[p] = nxt;
        if (hi) m_out[p] = 1'b1;
        else if (lo) m_out[p] = 1'b0;
      end
    end
    if (cfg_we && cfg_word[31:30] == 2'b01) begin
      m_dc[cfg_word[29:28]]   = cfg_word[6:5];
      m_rate[cfg_word[29:28]] = cfg_word[4:0];
    end
    @(negedge clk);
    m_k++;
  endtask

  task automatic rand_raw(input int skip);
    for (int p = 0; p < NP; p++) begin
      if (p != skip) begin
        if (hold_left[p] == 0) begin
          pin_raw[p] = ~pin_raw[p];
          hold_left[p] = ($urandom % 3 == 0) ? 1 + int'($urandom % 3) : 1 + int'($urandom % 120);
        end else hold_left[p]--;
      end
    end
  endtask

  task automatic do_write(input logic [31:0] w);
    cfg_we = 1'b1;
    cfg_word = w;
    rand_raw(-1);
    tick();
    cfg_we = 1'b0;
    cfg_word = $urandom;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    m_dc = '{2'd0, 2'd1, 2'd2, 2'd3};
    m_rate = '{5'd0, 5'd5, 5'd19, 5'd22};
    for (int p = 0; p < NP; p++) begin
      m_pipe[p] = '0; m_out[p] = 1'b0; hold_left[p] = 0;
    end
    pin_sel = {3'b110, 3'b011, 3'b101, 3'b100};
    m_k = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(pin_out[0] == 0, "R1", pin_out[0], 0);
    check(pin_out[1] == 0, "R1", pin_out[1], 0);
    check(pin_out[3] == 0, "R1", pin_out[3], 0);
    check(samp_en == 4'b0001, "R8", samp_en, 1);

    // depth 2 at full rate: two high samples raise the output
    pin_raw[0] = 1'b1;
    tick();
    check(pin_out[0] == 0, "R9", pin_out[0], 0);
    tick();
    check(pin_out[0] == 1, "R9", pin_out[0], 1);

    while (m_k < 31) begin rand_raw(0); tick(); end
    #1;
    check(samp_en[1] == 1, "R8", samp_en[1], 1);
    check(samp_en[3:2] == 2'b00, "R8", samp_en[3:2], 0);
    repeat (300) begin rand_raw(-1); tick(); end

    // untagged write: rate 4 in setting 0 must not appear
    do_write({2'b10, 2'b00, 21'h1abcde, 2'b11, 5'd4});
    #1;
    check(samp_en[0] == 1, "R3", samp_en[0], 1);

    do_write({2'b01, 2'b10, 21'($urandom), 2'b10, 5'd2});
    do_write({2'b01, 2'b11, 21'($urandom), 2'b00, 5'd1});
    do_write({2'b01, 2'b01, 21'($urandom), 2'b01, 5'd3});
    do_write({2'b01, 2'b00, 21'($urandom), 2'b11, 5'd0});
    #1;
    check(samp_en[0] == 1, "R2", samp_en[0], 1);

    // depth 8: seven highs are a glitch, eight are a level
    pin_raw[0] = 1'b0;
    repeat (10) begin rand_raw(0); tick(); end
    check(pin_out[0] == 0, "R6", pin_out[0], 0);
    pin_raw[0] = 1'b1;
    repeat (7) begin rand_raw(0); tick(); end
    pin_raw[0] = 1'b0;
    rand_raw(0); tick();
    check(pin_out[0] == 0, "R4", pin_out[0], 0);
    pin_raw[0] = 1'b1;
    repeat (7) begin rand_raw(0); tick(); end
    check(pin_out[0] == 0, "R4", pin_out[0], 0);
    rand_raw(0); tick();
    check(pin_out[0] == 1, "R4", pin_out[0], 1);

    repeat (6000) begin
      if ($urandom % 50 == 0) begin
        logic [31:0] w;
        w = $urandom;
        if ($urandom % 4 != 0) w[31:30] = 2'b01;
        w[4:0] = 5'($urandom % 6);
        do_write(w);
      end else begin
        for (int p = 0; p < NP; p++)
          if ($urandom % 100 == 0) pin_sel[p*3 +: 3] = 3'($urandom);
        rand_raw(-1);
        tick();
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule